// File: doc/BRIEF.md
# Fixed-Table Periodic Task Dispatcher

This block hands out time to a small set of periodic software or hardware tasks. It divides the system clock down to a 1024 Hz scheduling tick. On each tick it steps a slot index through a 64-entry frame, so the frame repeats 16 times per second. Every slot belongs to at most one task. When the tick lands on a slot, the owner of that slot gets a grant pulse that lasts one clock cycle. A slot with no owner produces no grant.

There are five tasks, each with its own fixed grant rate:

| Task | Grants per second |
|------|-------------------|
| Science-instrument service | 512 |
| Transmit | 256 |
| Magnetometer sampling | 128 |
| Command handling | 32 |
| Attenuator control | 16 |

The slot assignment is chosen so that two tasks never share a slot. A consumer can also follow the slot index output and a frame-start pulse to align its own work to the frame. A synchronous clear restarts both the frame and the tick divider.

The owner of each slot is decided by a period/phase rule. A task owns slot `s` when `s mod period == phase`, with a power-of-two period. Before elaboration, the tool checks that the rule set is free of collisions and that the rates fit the frame.

Top module: `slot_sched`

## Requirements
- R1: While reset is held and just after it, `grant_o` is 0, `slot_o` is 0 and `frame_o` is 0.
- R2: A tick occurs once every CLK_HZ/TICK_HZ clocks. The first tick comes that many clocks after reset or clear. Each tick serves the next slot, starting at 0 and wrapping from 63 to 0. From the clock edge of the tick, `slot_o` shows the slot being served.
- R3: Grant bits are assigned as follows:
  - bit 0 (command) on slots 6 and 38;
  - bit 1 (transmit) on slots divisible by 4;
  - bit 2 (science) on odd slots;
  - bit 3 (magnetometer) on slots equal to 2 mod 8;
  - bit 4 (attenuator) on slot 14.
  Slots 22, 30, 46, 54 and 62 grant nothing.
- R4: At most one grant bit is high in any cycle.
- R5: Each grant is high for exactly one clock cycle, in the cycle after the tick edge.
- R6: `frame_o` pulses for one cycle when slot 0 is served, and at no other time.
- R7: Over one frame, the grant counts are 32 science, 16 transmit, 8 magnetometer, 2 command and 1 attenuator, with 5 idle slots.
- R8: A clear that falls between ticks has these effects. In the next cycle, `grant_o`, `slot_o` and `frame_o` are 0. No grant appears until a full tick period has passed. The tick that follows then serves slot 0.
- R9: A clear on the same edge as a tick overrides the tick. That slot is not granted, and slot 0 is served one full tick period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of frame and tick divider |
| grant_o | output | 5 | One-cycle task grants: bit 0 command, bit 1 transmit, bit 2 science, bit 3 magnetometer, bit 4 attenuator |
| slot_o | output | 6 | Slot index most recently served |
| frame_o | output | 1 | One-cycle pulse when slot 0 is served |

## Verification
The hardest case to reach is a clear that lands on exactly the same edge as a tick, because the divider phase cannot be seen at the ports. The bench runs the divider with a period of four clocks and counts clock edges from reset. This tells it exactly which edge carries each tick, so it drives clear onto that edge. It also drives a second clear between ticks, to show that the old tick phase is dropped. A full two-frame walk covers every slot owner and the wrap from 63 to 0.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

   localparam int NTASK = 5;

   // grant bit positions
   localparam int IDX_CMD = 0;
   localparam int IDX_TX  = 1;
   localparam int IDX_SCI = 2;
   localparam int IDX_MAG = 3;
   localparam int IDX_ATT = 4;

   // a task owns slot s when (s mod period) == phase; period is a power of two
   localparam int TASK_PERIOD [NTASK] = '{32, 4, 2, 8, 64};
   localparam int TASK_PHASE  [NTASK] = '{ 6, 0, 1, 2, 14};

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int owners_of(input int slot);
      int n;
      n = 0;
      for (int t = 0; t < NTASK; t++)
         if ((slot % TASK_PERIOD[t]) == TASK_PHASE[t]) n++;
      return n;
   endfunction

   function automatic bit table_clean(input int nslots);
      for (int s = 0; s < nslots; s++)
         if (owners_of(s) > 1) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit table_fits(input int nslots);
      for (int t = 0; t < NTASK; t++) begin
         if (!is_pow2(TASK_PERIOD[t]))      return 1'b0;
         if (TASK_PERIOD[t] > nslots)       return 1'b0;
         if (TASK_PHASE[t] >= TASK_PERIOD[t]) return 1'b0;
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/sched_tick_gen.sv
module sched_tick_gen #(
   parameter int DIV = 48828
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("sched_tick_gen: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clear)        cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);
endmodule

// File: rtl/sched_slot_counter.sv
module sched_slot_counter #(
   parameter int NSLOTS = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      tick,
   output logic [$clog2(NSLOTS)-1:0] next_slot
);
   localparam int SW = $clog2(NSLOTS);

   logic [SW-1:0] slot_q;

   // power-of-two NSLOTS wraps naturally
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q <= '0;
      else if (clear) slot_q <= '0;
      else if (tick)  slot_q <= slot_q + 1'b1;
   end

   assign next_slot = slot_q;
endmodule

// File: rtl/sched_slot_decoder.sv
module sched_slot_decoder
   import slot_sched_pkg::*;
#(
   parameter int SLOT_W = 6
) (
   input  logic [SLOT_W-1:0] slot,
   output logic [NTASK-1:0]  owner
);
   for (genvar t = 0; t < NTASK; t++) begin : g_task
      localparam logic [SLOT_W-1:0] MASK  = SLOT_W'(TASK_PERIOD[t] - 1);
      localparam logic [SLOT_W-1:0] PHASE = SLOT_W'(TASK_PHASE[t]);
      assign owner[t] = ((slot & MASK) == PHASE);
   end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
   import slot_sched_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int TICK_HZ  = 1024,
   parameter int FRAME_HZ = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [NTASK-1:0] grant_o,
   output logic [5:0]       slot_o,
   output logic             frame_o
);
   localparam int NSLOTS   = TICK_HZ / FRAME_HZ;
   localparam int SLOT_W   = $clog2(NSLOTS);
   localparam int TICK_DIV = CLK_HZ / TICK_HZ;

   // elaboration checks
   if (!is_pow2(NSLOTS) || (NSLOTS * FRAME_HZ != TICK_HZ)) begin : g_bad_frame
      $error("slot_sched: tick rate must be a power-of-two multiple of frame rate");
   end
   if (SLOT_W != 6) begin : g_bad_width
      $error("slot_sched: slot output is sized for a 64-slot frame");
   end
   if (!table_fits(NSLOTS)) begin : g_bad_table
      $error("slot_sched: task period/phase table does not fit the frame");
   end
   if (!table_clean(NSLOTS)) begin : g_collide
      $error("slot_sched: two tasks share a slot");
   end

   logic              tick;
   logic [SLOT_W-1:0] next_slot;
   logic [NTASK-1:0]  owner;

   sched_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(clear),
      .tick (tick)
   );

   sched_slot_counter #(.NSLOTS(NSLOTS)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .tick     (tick),
      .next_slot(next_slot)
   );

   sched_slot_decoder #(.SLOT_W(SLOT_W)) u_dec (
      .slot (next_slot),
      .owner(owner)
   );

   // one output flop per task grant
   for (genvar t = 0; t < NTASK; t++) begin : g_grant
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     grant_o[t] <= 1'b0;
         else if (clear) grant_o[t] <= 1'b0;
         else            grant_o[t] <= tick & owner[t];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_o  <= '0;
         frame_o <= 1'b0;
      end else if (clear) begin
         slot_o  <= '0;
         frame_o <= 1'b0;
      end else begin
         frame_o <= tick && (next_slot == '0);
         if (tick) slot_o <= next_slot;
      end
   end
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk
   import slot_sched_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic [NTASK-1:0] grant,
   input logic [5:0]       slot,
   input logic             frame
);
   assert_onehot_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |=> (grant == '0));

   assert_frame_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame |-> (slot == 6'd0));

   assert_frame_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame |=> !frame);

   assert_science_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant[IDX_SCI] |-> slot[0]);

   assert_clear_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (grant == '0 && slot == 6'd0 && !frame));
endmodule

bind slot_sched slot_sched_chk u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .clear(clear),
   .grant(grant_o),
   .slot (slot_o),
   .frame(frame_o)
);

// File: tb/slot_sched_tb_top.sv
module slot_sched_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clear = 1'b0;
   logic [4:0] grant_o;
   logic [5:0] slot_o;
   logic       frame_o;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   slot_sched #(.CLK_HZ(4096), .TICK_HZ(1024), .FRAME_HZ(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .grant_o(grant_o), .slot_o(slot_o), .frame_o(frame_o)
   );

   typedef struct packed { logic [5:0] slot; logic [4:0] grant; } vec_t;
   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{6'd0,  5'b00010}, '{6'd1,  5'b00100}, '{6'd2,  5'b01000},
      '{6'd6,  5'b00001}, '{6'd14, 5'b10000}, '{6'd22, 5'b00000},
      '{6'd38, 5'b00001}, '{6'd44, 5'b00010}, '{6'd50, 5'b01000},
      '{6'd54, 5'b00000}, '{6'd62, 5'b00000}, '{6'd63, 5'b00100}
   };

   function automatic logic [4:0] model(input int s);
      logic [4:0] g;
      g = '0;
      if (s == 6 || s == 38) g[0] = 1'b1;
      if (s % 4 == 0)        g[1] = 1'b1;
      if (s % 2 == 1)        g[2] = 1'b1;
      if (s % 8 == 2)        g[3] = 1'b1;
      if (s == 14)           g[4] = 1'b1;
      return g;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   logic [4:0] obs [64];
   int cnt [5];
   int idle;

   initial begin
      int pend;
      repeat (3) @(negedge clk);
      check(grant_o == 0 && slot_o == 0 && !frame_o, "R1 reset state", {grant_o, slot_o, frame_o}, 0);
      rst_n = 1'b1;
      check(grant_o == 0 && slot_o == 0 && !frame_o, "R1 after release", {grant_o, slot_o, frame_o}, 0);

      for (int t = 0; t < 5; t++) cnt[t] = 0;
      idle = 0;
      pend = 4;
      for (int k = 0; k < 128; k++) begin
         int s;
         s = k % 64;
         repeat (pend) @(posedge clk);
         @(negedge clk);
         check(grant_o == model(s), "R3 slot owner", grant_o, model(s));
         check(slot_o == 6'(s), "R2 slot index", slot_o, s);
         check(frame_o == (s == 0), "R6 frame pulse", frame_o, (s == 0));
         check($countones(grant_o) <= 1, "R4 single grant", grant_o, 0);
         if (k < 64) begin
            obs[s] = grant_o;
            for (int t = 0; t < 5; t++) if (grant_o[t]) cnt[t]++;
            if (grant_o == 0) idle++;
         end
         @(posedge clk);
         @(negedge clk);
         check(grant_o == 0, "R5 grant one cycle", grant_o, 0);
         check(!frame_o, "R6 frame one cycle", frame_o, 0);
         pend = 3;
      end

      for (int v = 0; v < NVEC; v++)
         check(obs[VECS[v].slot] == VECS[v].grant, "R3 table vector",
               obs[VECS[v].slot], VECS[v].grant);

      check(cnt[2] == 32, "R7 science count", cnt[2], 32);
      check(cnt[1] == 16, "R7 transmit count", cnt[1], 16);
      check(cnt[3] == 8,  "R7 magnetometer count", cnt[3], 8);
      check(cnt[0] == 2,  "R7 command count", cnt[0], 2);
      check(cnt[4] == 1,  "R7 attenuator count", cnt[4], 1);
      check(idle == 5,    "R7 idle count", idle, 5);

      // R8: clear between ticks (next tick would be 3 posedges away)
      @(posedge clk);
      @(negedge clk) clear = 1'b1;
      @(posedge clk);
      @(negedge clk) clear = 1'b0;
      check(grant_o == 0 && slot_o == 0 && !frame_o, "R8 clear state", {grant_o, slot_o, frame_o}, 0);
      @(posedge clk);
      @(negedge clk);
      check(grant_o == 0, "R8 old tick phase dropped", grant_o, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(grant_o == 0, "R8 quiet until tick", grant_o, 0);
      @(posedge clk);
      @(negedge clk);
      check(grant_o == 5'b00010 && slot_o == 0 && frame_o, "R8 restart at slot 0",
            {grant_o, slot_o, frame_o}, {5'b00010, 6'd0, 1'b1});

      // R9: clear on the tick edge (slot 1 would be served)
      repeat (3) @(posedge clk);
      @(negedge clk) clear = 1'b1;
      @(posedge clk);
      @(negedge clk) clear = 1'b0;
      check(grant_o == 0 && slot_o == 0 && !frame_o, "R9 clear beats tick",
            {grant_o, slot_o, frame_o}, 0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(grant_o == 5'b00010 && slot_o == 0 && frame_o, "R9 slot 0 after clear",
            {grant_o, slot_o, frame_o}, {5'b00010, 6'd0, 1'b1});
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(grant_o == 5'b00100 && slot_o == 1, "R9 slot 1 follows",
            {grant_o, slot_o}, {5'b00100, 6'd1});

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule